// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a 32-bit load/store processor core that runs each instruction as a short series of clock steps instead of one long cycle. A single ALU and a single memory port are shared by all steps. Values that must survive from one step to the next are held in internal registers: the instruction register, two operand registers, an ALU result register and a memory data register. The memory port carries both instruction fetches and data loads and stores, so an instruction needs between two and five cycles depending on its kind.

Every instruction begins with the same two steps. The fetch step reads the instruction and advances the PC by four. The decode step reads both source registers and speculatively forms a branch target, whatever the instruction turns out to be. The later steps depend on the opcode. A debug output shows the PC and the step currently in progress, so that a surrounding system or bench can follow execution. The memory read path is combinational, and memory writes take effect on the clock edge while write enable is high.

Top module: `mc_core`

## Requirements
- R1: A synchronous reset sets the PC to 0 and the step code on `dbgState` to 0 (fetch). The step codes are fetch 0, decode 1, address 2, load-read 3, store 4, load-writeback 5, execute 6, R-writeback 7, branch 8, jump 9.
- R2: In the fetch step the core presents the PC on `memAddr` with `memWe` low, captures `memRdata` as the instruction, and the PC reads PC+4 after that edge. Instruction fields are op [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], imm16 [15:0], addr26 [25:0].
- R3: The decode step loads rs and rt into the operand registers, leaves the PC unchanged, and forms the branch target as (PC+4) + (sign-extended imm16 << 2).
- R4: An R-type instruction (op 000000) takes 4 cycles and writes rs op rt into rd, with funct 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 signed set-less-than (result 1 or 0).
- R5: A load word (op 100011) takes 5 cycles, reads memory at rs + sign-extended imm16 and writes the word into rt.
- R6: A store word (op 101011) takes 4 cycles and writes rt to memory at rs + sign-extended imm16; `memWe` is high only in the store step (code 4).
- R7: A branch-if-equal (op 000100) takes 3 cycles; when rs equals rt the next fetch is at the decode-formed target, otherwise at PC+4.
- R8: A jump (op 000010) takes 3 cycles and sets the PC to {PC+4 [31:28], addr26, 00}.
- R9: Register 0 reads as zero at all times; a write that targets it leaves it zero.
- R10: Any other opcode does nothing and returns to fetch after decode, taking 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 32 | Byte address for the shared memory port |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Combinational read data for `memAddr` |
| memWe | output | 1 | Write enable, sampled on the rising edge |
| dbgPc | output | 32 | Current PC register |
| dbgState | output | 4 | Current step code (see R1) |

## Verification
Each instruction's latency is measured as the number of clock edges between one fetch step and the next: 5 for a load, 4 for an R-type or store, 3 for a branch or jump and 2 for an unknown opcode. The PC of every fetch is compared against the expected flow, and this includes the cycle that follows a taken branch or a jump. Outputs are sampled on the falling edge, so each step's effect is read half a cycle after the edge that produced it. Register results are brought out by later store instructions and checked in the bench memory after the program has finished. The new PC after a fetch, a PC that stays put through decode, and write enable appearing only in the store step are all checked edge by edge.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int XLEN    = 32;
  localparam int OP_W    = 6;
  localparam int FUNCT_W = 6;
  localparam int RIDX_W  = 5;
  localparam int IMM_W   = 16;
  localparam int JADDR_W = 26;
  localparam int STATE_W = 4;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LW    = 6'b100011;
  localparam logic [OP_W-1:0] OP_SW    = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_J     = 6'b000010;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDRD   = 4'd3,
    ST_STORE  = 4'd4,
    ST_LDWB   = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } step_t;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'd0,
    ALU_SUB   = 2'd1,
    ALU_FUNCT = 2'd2
  } aluMode_t;

  typedef enum logic [1:0] {
    SRCB_REG  = 2'd0,
    SRCB_FOUR = 2'd1,
    SRCB_IMM  = 2'd2,
    SRCB_BOFS = 2'd3
  } srcB_t;

  typedef enum logic [1:0] {
    PCN_ALU  = 2'd0,
    PCN_HELD = 2'd1,
    PCN_JUMP = 2'd2
  } pcNext_t;

  typedef struct packed {
    logic     pcWrite;
    logic     pcWriteEq;
    pcNext_t  pcSel;
    logic     dataAddr;
    logic     memWrite;
    logic     irLoad;
    logic     opLoad;
    logic     resLoad;
    logic     mdrLoad;
    logic     regWrite;
    logic     dstRd;
    logic     wbFromMem;
    logic     srcAReg;
    srcB_t    srcB;
    aluMode_t aluMode;
  } strobes_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int WIDTH = XLEN
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  aluMode_t           mode,
  input  logic [FUNCT_W-1:0] funct,
  output logic [WIDTH-1:0]   result,
  output logic               isZero
);

  typedef enum logic [2:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_SLT
  } kind_t;

  kind_t kind;

  always_comb begin
    unique case (mode)
      ALU_SUB:   kind = K_SUB;
      ALU_FUNCT: begin
        case (funct)
          FN_SUB:  kind = K_SUB;
          FN_AND:  kind = K_AND;
          FN_OR:   kind = K_OR;
          FN_SLT:  kind = K_SLT;
          default: kind = K_ADD;
        endcase
      end
      default:   kind = K_ADD;
    endcase
  end

  always_comb begin
    case (kind)
      K_SUB:   result = opA - opB;
      K_AND:   result = opA & opB;
      K_OR:    result = opA | opB;
      K_SLT:   result = ($signed(opA) < $signed(opB)) ? WIDTH'(1) : '0;
      default: result = opA + opB;
    endcase
  end

  assign isZero = (result == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int WIDTH = XLEN,
  parameter int NREG  = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic [AW-1:0]    rdAddrA,
  input  logic [AW-1:0]    rdAddrB,
  output logic [WIDTH-1:0] rdDataA,
  output logic [WIDTH-1:0] rdDataB,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData
);

  logic [WIDTH-1:0] regs [NREG];

  // Entry 0 is never written and always reads as zero.
  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr != '0)) regs[wrAddr] <= wrData;
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output strobes_t        strb,
  output step_t           step
);

  step_t stepNext;

  always_ff @(posedge clk) begin
    if (rst) step <= ST_FETCH;
    else     step <= stepNext;
  end

  always_comb begin
    stepNext = ST_FETCH;
    unique case (step)
      ST_FETCH:  stepNext = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_LW, OP_SW: stepNext = ST_ADDR;
          OP_RTYPE:     stepNext = ST_EXEC;
          OP_BEQ:       stepNext = ST_BRANCH;
          OP_J:         stepNext = ST_JUMP;
          default:      stepNext = ST_FETCH;
        endcase
      end
      ST_ADDR:   stepNext = (opcode == OP_LW) ? ST_LDRD : ST_STORE;
      ST_LDRD:   stepNext = ST_LDWB;
      ST_EXEC:   stepNext = ST_RWB;
      default:   stepNext = ST_FETCH;
    endcase
  end

  always_comb begin
    strb = '0;
    unique case (step)
      ST_FETCH: begin
        strb.irLoad  = 1'b1;
        strb.srcB    = SRCB_FOUR;
        strb.aluMode = ALU_ADD;
        strb.pcWrite = 1'b1;
        strb.pcSel   = PCN_ALU;
      end
      ST_DECODE: begin
        strb.opLoad  = 1'b1;
        strb.srcB    = SRCB_BOFS;
        strb.aluMode = ALU_ADD;
        strb.resLoad = 1'b1;
      end
      ST_ADDR: begin
        strb.srcAReg = 1'b1;
        strb.srcB    = SRCB_IMM;
        strb.aluMode = ALU_ADD;
        strb.resLoad = 1'b1;
      end
      ST_LDRD: begin
        strb.dataAddr = 1'b1;
        strb.mdrLoad  = 1'b1;
      end
      ST_STORE: begin
        strb.dataAddr = 1'b1;
        strb.memWrite = 1'b1;
      end
      ST_LDWB: begin
        strb.regWrite  = 1'b1;
        strb.wbFromMem = 1'b1;
      end
      ST_EXEC: begin
        strb.srcAReg = 1'b1;
        strb.srcB    = SRCB_REG;
        strb.aluMode = ALU_FUNCT;
        strb.resLoad = 1'b1;
      end
      ST_RWB: begin
        strb.regWrite = 1'b1;
        strb.dstRd    = 1'b1;
      end
      ST_BRANCH: begin
        strb.srcAReg   = 1'b1;
        strb.srcB      = SRCB_REG;
        strb.aluMode   = ALU_SUB;
        strb.pcWriteEq = 1'b1;
        strb.pcSel     = PCN_HELD;
      end
      ST_JUMP: begin
        strb.pcWrite = 1'b1;
        strb.pcSel   = PCN_JUMP;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  strobes_t        strb,
  output logic [OP_W-1:0] opcode,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] pcOut
);

  localparam int RS_LSB = IMM_W + RIDX_W;
  localparam int RT_LSB = IMM_W;
  localparam int RD_LSB = IMM_W - RIDX_W;

  logic [XLEN-1:0] pc, ir, aReg, bReg, resReg, mdr;
  logic [XLEN-1:0] rfA, rfB, aluA, aluB, aluY, immExt, jumpTarget, pcNext, wbData;
  logic [RIDX_W-1:0] rsIdx, rtIdx, rdIdx, wbIdx;
  logic aluZero;

  assign opcode     = ir[XLEN-1 -: OP_W];
  assign rsIdx      = ir[RS_LSB +: RIDX_W];
  assign rtIdx      = ir[RT_LSB +: RIDX_W];
  assign rdIdx      = ir[RD_LSB +: RIDX_W];
  assign immExt     = {{(XLEN-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
  assign jumpTarget = {pc[XLEN-1 -: (XLEN-JADDR_W-2)], ir[JADDR_W-1:0], 2'b00};

  mc_regfile #(.WIDTH(XLEN), .NREG(NREG)) regfile_i (
    .clk    (clk),
    .rdAddrA(rsIdx),
    .rdAddrB(rtIdx),
    .rdDataA(rfA),
    .rdDataB(rfB),
    .wrEn   (strb.regWrite),
    .wrAddr (wbIdx),
    .wrData (wbData)
  );

  assign aluA = strb.srcAReg ? aReg : pc;

  always_comb begin
    unique case (strb.srcB)
      SRCB_FOUR: aluB = XLEN'(4);
      SRCB_IMM:  aluB = immExt;
      SRCB_BOFS: aluB = immExt << 2;
      default:   aluB = bReg;
    endcase
  end

  mc_alu #(.WIDTH(XLEN)) alu_i (
    .opA   (aluA),
    .opB   (aluB),
    .mode  (strb.aluMode),
    .funct (ir[FUNCT_W-1:0]),
    .result(aluY),
    .isZero(aluZero)
  );

  always_comb begin
    unique case (strb.pcSel)
      PCN_HELD: pcNext = resReg;
      PCN_JUMP: pcNext = jumpTarget;
      default:  pcNext = aluY;
    endcase
  end

  assign wbIdx  = strb.dstRd ? rdIdx : rtIdx;
  assign wbData = strb.wbFromMem ? mdr : resReg;

  assign memAddr  = strb.dataAddr ? resReg : pc;
  assign memWdata = bReg;
  assign pcOut    = pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      ir     <= '0;
      aReg   <= '0;
      bReg   <= '0;
      resReg <= '0;
      mdr    <= '0;
    end else begin
      if (strb.pcWrite || (strb.pcWriteEq && aluZero)) pc <= pcNext;
      if (strb.irLoad)  ir     <= memRdata;
      if (strb.opLoad) begin
        aReg <= rfA;
        bReg <= rfB;
      end
      if (strb.resLoad) resReg <= aluY;
      if (strb.mdrLoad) mdr    <= memRdata;
    end
  end

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic                clk,
  input  logic                rst,
  output logic [XLEN-1:0]     memAddr,
  output logic [XLEN-1:0]     memWdata,
  input  logic [XLEN-1:0]     memRdata,
  output logic                memWe,
  output logic [XLEN-1:0]     dbgPc,
  output logic [STATE_W-1:0]  dbgState
);

  strobes_t        strb;
  step_t           step;
  logic [OP_W-1:0] opcode;

  mc_ctrl ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .opcode(opcode),
    .strb  (strb),
    .step  (step)
  );

  mc_datapath #(.NREG(NREG)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .opcode  (opcode),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .memRdata(memRdata),
    .pcOut   (dbgPc)
  );

  assign memWe    = strb.memWrite;
  assign dbgState = step;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [XLEN-1:0]    memAddr,
  input logic               memWe,
  input logic [XLEN-1:0]    dbgPc,
  input logic [STATE_W-1:0] dbgState
);

  AST_RESET_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dbgState == 4'd0 && dbgPc == '0)) else $error("reset state"); // R1

  AST_FETCH_PORT: assert property (@(posedge clk) disable iff (rst)
    (dbgState == 4'd0) |-> (memAddr == dbgPc && !memWe)) else $error("fetch port"); // R2

  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (dbgState == 4'd0) |=> (dbgPc == $past(dbgPc) + 32'd4)) else $error("pc advance"); // R2

  AST_DECODE_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dbgState == 4'd1) |=> $stable(dbgPc)) else $error("decode pc"); // R3

  AST_DECODE_BRANCHES: assert property (@(posedge clk) disable iff (rst)
    (dbgState == 4'd1) |=> (dbgState inside {4'd0, 4'd2, 4'd6, 4'd8, 4'd9})) else $error("decode next"); // R10

  AST_WE_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (dbgState == 4'd4)) else $error("write enable"); // R6

  AST_WB_ENDS: assert property (@(posedge clk) disable iff (rst)
    (dbgState == 4'd5 || dbgState == 4'd7) |=> (dbgState == 4'd0)) else $error("writeback end"); // R4

  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (dbgState <= 4'd9)) else $error("step code"); // R1

endmodule

bind mc_core mc_core_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .memAddr (memAddr),
  .memWe   (memWe),
  .dbgPc   (dbgPc),
  .dbgState(dbgState)
);

// File: tb/mc_core_tb_top.sv
`timescale 1ns/1ps
module mc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] memAddr, memWdata, memRdata, dbgPc;
  logic        memWe;
  logic [3:0]  dbgState;

  logic [31:0] mem [128];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mc_core dut_i (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memWe(memWe), .dbgPc(dbgPc), .dbgState(dbgState)
  );

  assign memRdata = mem[memAddr[8:2]];
  always @(posedge clk) if (memWe) mem[memAddr[8:2]] <= memWdata;

  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] encR(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] encJ(logic [25:0] target);
    return {6'b000010, target};
  endfunction

  function automatic string tagOf(int kind);
    case (kind)
      0: return "R5";
      1: return "R4";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  // {fetch PC[15:0], cycles[7:0], kind[7:0]}; kind 0 load,1 R-type,2 store,3 branch,4 jump,5 unknown
  localparam logic [31:0] TRACE [23] = '{
    {16'd0,   8'd5, 8'd0}, {16'd4,   8'd5, 8'd0},
    {16'd8,   8'd4, 8'd1}, {16'd12,  8'd4, 8'd1}, {16'd16, 8'd4, 8'd1},
    {16'd20,  8'd4, 8'd1}, {16'd24,  8'd4, 8'd1}, {16'd28, 8'd4, 8'd1},
    {16'd32,  8'd4, 8'd1},
    {16'd36,  8'd4, 8'd2}, {16'd40,  8'd4, 8'd2}, {16'd44, 8'd4, 8'd2},
    {16'd48,  8'd4, 8'd2}, {16'd52,  8'd4, 8'd2}, {16'd56, 8'd4, 8'd2},
    {16'd60,  8'd4, 8'd2},
    {16'd64,  8'd3, 8'd3}, {16'd68,  8'd3, 8'd3},
    {16'd80,  8'd3, 8'd4},
    {16'd96,  8'd2, 8'd5},
    {16'd100, 8'd5, 8'd0}, {16'd104, 8'd4, 8'd2},
    {16'd108, 8'd3, 8'd4}
  };

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    mem[0]  = encI(6'b100011, 5'd0, 5'd1, 16'h0100);
    mem[1]  = encI(6'b100011, 5'd0, 5'd2, 16'h0104);
    mem[2]  = encR(5'd1, 5'd2, 5'd3, 6'b100000);
    mem[3]  = encR(5'd1, 5'd2, 5'd4, 6'b100010);
    mem[4]  = encR(5'd1, 5'd2, 5'd5, 6'b100100);
    mem[5]  = encR(5'd1, 5'd2, 5'd6, 6'b100101);
    mem[6]  = encR(5'd2, 5'd1, 5'd7, 6'b101010);
    mem[7]  = encR(5'd1, 5'd2, 5'd8, 6'b101010);
    mem[8]  = encR(5'd1, 5'd1, 5'd0, 6'b100000);
    mem[9]  = encI(6'b101011, 5'd0, 5'd3, 16'h0108);
    mem[10] = encI(6'b101011, 5'd0, 5'd4, 16'h010C);
    mem[11] = encI(6'b101011, 5'd0, 5'd5, 16'h0110);
    mem[12] = encI(6'b101011, 5'd0, 5'd6, 16'h0114);
    mem[13] = encI(6'b101011, 5'd0, 5'd7, 16'h0118);
    mem[14] = encI(6'b101011, 5'd0, 5'd8, 16'h011C);
    mem[15] = encI(6'b101011, 5'd0, 5'd0, 16'h0120);
    mem[16] = encI(6'b000100, 5'd1, 5'd2, 16'd5);
    mem[17] = encI(6'b000100, 5'd1, 5'd1, 16'd2);
    mem[18] = encI(6'b101011, 5'd0, 5'd1, 16'h0124);
    mem[19] = encI(6'b101011, 5'd0, 5'd1, 16'h0124);
    mem[20] = encJ(26'd24);
    mem[21] = encI(6'b101011, 5'd0, 5'd1, 16'h0124);
    mem[22] = encI(6'b101011, 5'd0, 5'd1, 16'h0124);
    mem[23] = encI(6'b101011, 5'd0, 5'd1, 16'h0124);
    mem[24] = 32'hFC00_0000;
    mem[25] = encI(6'b100011, 5'd0, 5'd9, 16'h0128);
    mem[26] = encI(6'b101011, 5'd9, 5'd1, 16'hFFFC);
    mem[27] = encJ(26'd27);
    mem[7'h40] = 32'd5;
    mem[7'h41] = 32'hFFFF_FFF7;
    mem[7'h48] = 32'hDEAD_BEEF;
    mem[7'h49] = 32'h1111_1111;
    mem[7'h4A] = 32'h0000_0130;
    mem[7'h4B] = 32'h0;

    repeat (3) @(negedge clk);
    check("R1", "reset pc", dbgPc, 32'h0);
    check("R1", "reset step", {28'h0, dbgState}, 32'h0);
    rst = 1'b0;

    // Vector walk: every fetch PC and every instruction latency.
    for (int k = 0; k < 23; k++) begin
      int n;
      int exPc, exCyc, kind;
      exPc  = int'(TRACE[k][31:16]);
      exCyc = int'(TRACE[k][15:8]);
      kind  = int'(TRACE[k][7:0]);
      if (k == 18) check("R3", "taken branch target", dbgPc, 32'd80);
      check("R2", "fetch pc", dbgPc, 32'(exPc));
      check("R2", "fetch address", memAddr, 32'(exPc));
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (dbgState != 4'd0 && n < 20);
      check(tagOf(kind), "cycles", 32'(n), 32'(exCyc));
    end
    check("R8", "jump to self", dbgPc, 32'd108);

    // Results brought out by stores.
    check("R4", "add", mem[7'h42], 32'hFFFF_FFFC);
    check("R4", "sub", mem[7'h43], 32'd14);
    check("R4", "and", mem[7'h44], 32'd5);
    check("R4", "or",  mem[7'h45], 32'hFFFF_FFF7);
    check("R4", "slt signed true",  mem[7'h46], 32'd1);
    check("R4", "slt signed false", mem[7'h47], 32'd0);
    check("R9", "r0 stays zero", mem[7'h48], 32'd0);
    check("R7", "skipped stores", mem[7'h49], 32'h1111_1111);
    check("R5", "load then negative offset store", mem[7'h4B], 32'd5);

    // Reset in the middle of execution.
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "mid-run reset pc", dbgPc, 32'h0);
    check("R1", "mid-run reset step", {28'h0, dbgState}, 32'h0);
    check("R6", "no write in reset", {31'h0, memWe}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule